// File: doc/BRIEF.md
# Masked fault input conditioner

This block takes sixteen active-low fault lines, where a line held high means the device is healthy and a low line means a fault. It decides whether the local station must OR its pattern into the next outgoing frame. Each line passes through a two-flop synchronizer and is then gated by its own enable bit. A fault lasting a single clock cycle after synchronization counts the same as a level held for many frames. It is caught in a pending latch and kept until the next frame insertion point consumes it.

Software has two further sources of faults. A level control forces a fault condition for as long as it is set. A one-cycle strobe requests exactly one frame of insertion. Insertion also needs a pattern-enable control: when that control is low at an insertion point, the pending fault is consumed without any insertion. A sticky flag records that any enabled line has faulted, and a status-read strobe clears it. The synchronized raw line levels are brought out for readback.

The decision is made by a four-state machine. Its states are the product of "insertion active in the current frame" and "fault pending for the next frame":
- **ST_QUIET**: no insertion, nothing pending.
- **ST_ARMED**: no insertion, a fault is pending.
- **ST_FIRING**: insertion active, nothing pending.
- **ST_REFIRE**: insertion active, a new fault is pending.

Transitions:
- **LATCH**: QUIET→ARMED or FIRING→REFIRE, when a fault hit arrives outside a frame slot.
- **FIRE**: any state→FIRING, at a slot where pattern_en is high and a fault is pending, hitting or forced.
- **DROP**: any state→QUIET, at a slot where no fault is pending, hitting or forced, or where pattern_en is low.
- **HOLD**: state unchanged, otherwise.

Top module: `fault_input_conditioner`

## Requirements
- R1: raw_snapshot shows fault_in_n as it was two clock edges earlier, with bit i for channel i. It is all ones out of reset.
- R2: A channel whose mask_en bit is 0 has no effect on insert_req or fault_seen, whatever its level.
- R3: An enabled channel that is low for a single synchronized cycle is held pending. At the next frame_slot edge, insert_req becomes 1 when pattern_en is high. insert_req keeps that value until the following frame_slot edge.
- R4: An enabled channel held low continuously gives insert_req = 1 in every frame.
- R5: When force_fault is high at a frame_slot edge and pattern_en is high, insert_req becomes 1, with all lines healthy.
- R6: A one-cycle pulse_fault_cmd strobe produces insert_req = 1 for exactly the one following frame.
- R7: When pattern_en is low at a frame_slot edge, insert_req becomes 0 and the pending fault is discarded. It does not carry into a later frame.
- R8: fault_seen goes to 1 one edge after any enabled synchronized line is low. It stays 1 until a status_rd cycle with no enabled fault present. If a read and a fault occur in the same cycle, the flag stays set.
- R9: After reset, insert_req = 0 and fault_seen = 0.
- R10: A fault that arrives while insertion is active in a frame is kept for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in_n | input | 16 | Fault lines, low = fault |
| mask_en | input | 16 | Per-channel enable, 1 = channel counts |
| force_fault | input | 1 | Continuous software fault |
| pulse_fault_cmd | input | 1 | One-cycle strobe for a single-frame fault |
| pattern_en | input | 1 | Pattern insertion allowed |
| frame_slot | input | 1 | One-cycle frame insertion point |
| status_rd | input | 1 | Status read strobe, clears fault_seen |
| insert_req | output | 1 | Insert pattern during the current frame |
| fault_seen | output | 1 | Sticky enabled-input fault flag |
| raw_snapshot | output | 16 | Synchronized line levels |

## Verification
Timing is counted from a line change made between edges. raw_snapshot follows it after the second edge. The pending latch and fault_seen react one edge later, that is, three edges after the change. insert_req changes only at the edge where frame_slot is sampled. The bench drives inputs and samples outputs on falling edges. A behavioural model updates at each rising edge and follows exactly this latency, and it is compared on every cycle. Directed checks wait at least four cycles after a line change before they pulse frame_slot, and then read insert_req on the falling edge right after the slot.

// File: rtl/fic_pkg.sv
package fic_pkg;

    // bit 1: insertion active this frame, bit 0: fault pending for next frame
    typedef enum logic [1:0] {
        ST_QUIET  = 2'b00,
        ST_ARMED  = 2'b01,
        ST_FIRING = 2'b10,
        ST_REFIRE = 2'b11
    } frame_state_e;

endpackage

// File: rtl/fic_sync.sv
module fic_sync #(
    parameter int   WIDTH     = 16,
    parameter int   STAGES    = 2,
    parameter logic RESET_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= {WIDTH{RESET_BIT}};
                    else        chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= {WIDTH{RESET_BIT}};
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/fic_qualify.sv
module fic_qualify #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] line_n,
    input  logic [WIDTH-1:0] enable,
    output logic             any_fault
);

    logic [WIDTH-1:0] active;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chan
            assign active[i] = enable[i] & ~line_n[i];
        end
    endgenerate

    assign any_fault = |active;

endmodule

// File: rtl/fic_frame_fsm.sv
module fic_frame_fsm
    import fic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic force_fault,
    input  logic frame_slot,
    input  logic pattern_en,
    output logic insert_req
);

    frame_state_e state_q, state_d;
    logic         fire_now;

    assign fire_now = pattern_en & (hit | force_fault);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (frame_slot)  state_d = fire_now ? ST_FIRING : ST_QUIET;
                else if (hit)    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (frame_slot)  state_d = pattern_en ? ST_FIRING : ST_QUIET;
            end
            ST_FIRING: begin
                if (frame_slot)  state_d = fire_now ? ST_FIRING : ST_QUIET;
                else if (hit)    state_d = ST_REFIRE;
            end
            ST_REFIRE: begin
                if (frame_slot)  state_d = pattern_en ? ST_FIRING : ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FIRING, ST_REFIRE: insert_req = 1'b1;
            default:              insert_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/fault_input_conditioner.sv
module fault_input_conditioner #(
    parameter int N_IN        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] fault_in_n,
    input  logic [N_IN-1:0] mask_en,
    input  logic            force_fault,
    input  logic            pulse_fault_cmd,
    input  logic            pattern_en,
    input  logic            frame_slot,
    input  logic            status_rd,
    output logic            insert_req,
    output logic            fault_seen,
    output logic [N_IN-1:0] raw_snapshot
);

    logic [N_IN-1:0] sync_n;
    logic            line_fault;
    logic            hit;

    fic_sync #(
        .WIDTH    (N_IN),
        .STAGES   (SYNC_STAGES),
        .RESET_BIT(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(fault_in_n),
        .q_sync (sync_n)
    );

    fic_qualify #(
        .WIDTH(N_IN)
    ) u_qual (
        .line_n   (sync_n),
        .enable   (mask_en),
        .any_fault(line_fault)
    );

    assign hit = line_fault | pulse_fault_cmd;

    fic_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .force_fault(force_fault),
        .frame_slot (frame_slot),
        .pattern_en (pattern_en),
        .insert_req (insert_req)
    );

    // sticky flag: a new fault in the read cycle wins over the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_seen <= 1'b0;
        else        fault_seen <= (fault_seen & ~status_rd) | line_fault;
    end

    assign raw_snapshot = sync_n;

endmodule

// File: rtl/fault_input_conditioner_chk.sv
module fault_input_conditioner_chk #(
    parameter int N_IN = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] fault_in_n,
    input logic [N_IN-1:0] mask_en,
    input logic            force_fault,
    input logic            pulse_fault_cmd,
    input logic            pattern_en,
    input logic            frame_slot,
    input logic            status_rd,
    input logic            insert_req,
    input logic            fault_seen,
    input logic [N_IN-1:0] raw_snapshot
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_snapshot_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (raw_snapshot == $past(fault_in_n, 2)));

    p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_slot |=> $stable(insert_req));

    p_force_inserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_slot && pattern_en && force_fault) |=> insert_req);

    p_strobe_inserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_slot && pattern_en && pulse_fault_cmd) |=> insert_req);

    p_disabled_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_slot && !pattern_en) |=> !insert_req);

    p_sticky_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_seen && !status_rd) |=> fault_seen);

    p_sticky_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd1) && $rose(fault_seen)) |-> $past(|(mask_en & ~raw_snapshot)));

endmodule

bind fault_input_conditioner fault_input_conditioner_chk #(.N_IN(N_IN)) u_chk (.*);

// File: tb/test_fault_input_conditioner.sv
`timescale 1ns/1ps
module test_fault_input_conditioner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fault_in_n = 16'hFFFF;
    logic [15:0] mask_en = 16'hFFFF;
    logic        force_fault = 1'b0;
    logic        pulse_fault_cmd = 1'b0;
    logic        pattern_en = 1'b1;
    logic        frame_slot = 1'b0;
    logic        status_rd = 1'b0;
    logic        insert_req;
    logic        fault_seen;
    logic [15:0] raw_snapshot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fault_input_conditioner i_fault_input_conditioner (
        .clk(clk), .rst_n(rst_n), .fault_in_n(fault_in_n), .mask_en(mask_en),
        .force_fault(force_fault), .pulse_fault_cmd(pulse_fault_cmd),
        .pattern_en(pattern_en), .frame_slot(frame_slot), .status_rd(status_rd),
        .insert_req(insert_req), .fault_seen(fault_seen), .raw_snapshot(raw_snapshot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic        m_out, m_pend, m_seen;
    logic [15:0] m_snap;
    logic [15:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_pend = 0; m_seen = 0; m_snap = 16'hFFFF;
            m_q = {16'hFFFF};
        end else begin
            logic flt, hit;
            flt = |(mask_en & ~m_snap);
            hit = flt | pulse_fault_cmd;
            if (frame_slot) begin
                m_out  = pattern_en & (m_pend | hit | force_fault);
                m_pend = 0;
            end else begin
                m_pend = m_pend | hit;
            end
            m_seen = (m_seen & ~status_rd) | flt;
            m_snap = m_q.pop_front();
            m_q.push_back(fault_in_n);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 model insert_req", insert_req, m_out);
            chk("R8 model fault_seen", fault_seen, m_seen);
            chk("R1 model raw_snapshot", raw_snapshot, m_snap);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic slot();
        @(negedge clk) frame_slot = 1;
        @(negedge clk) frame_slot = 0;
    endtask

    task automatic strobe_cmd();
        @(negedge clk) pulse_fault_cmd = 1;
        @(negedge clk) pulse_fault_cmd = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1;
        chk("R9 insert_req after reset", insert_req, 0);
        chk("R9 fault_seen after reset", fault_seen, 0);
        chk("R1 snapshot after reset", raw_snapshot, 16'hFFFF);

        // R2: masked channel 0 low has no effect
        mask_en = 16'hFFFE; fault_in_n = 16'hFFFE;
        idle(5); slot();
        chk("R2 masked insert_req", insert_req, 0);
        chk("R2 masked fault_seen", fault_seen, 0);
        fault_in_n = 16'hFFFF; idle(3);

        // R1: two-edge synchronizer latency, all masked
        mask_en = 16'h0000;
        @(negedge clk) fault_in_n = 16'h5A3C;
        @(negedge clk) chk("R1 snapshot one edge later", raw_snapshot, 16'hFFFF);
        @(negedge clk) chk("R1 snapshot two edges later", raw_snapshot, 16'h5A3C);
        fault_in_n = 16'hFFFF; idle(4); slot();
        mask_en = 16'hFFFF; idle(2);

        // R3: one-cycle fault on channel 5
        @(negedge clk) fault_in_n = 16'hFFDF;
        @(negedge clk) fault_in_n = 16'hFFFF;
        idle(4); slot();
        chk("R3 fast fault inserted", insert_req, 1);
        chk("R8 fast fault sets flag", fault_seen, 1);
        idle(3); slot();
        chk("R3 fast fault only one frame", insert_req, 0);

        // R8: read clears, fault in read cycle keeps flag
        @(negedge clk) status_rd = 1;
        @(negedge clk) status_rd = 0;
        chk("R8 read clears flag", fault_seen, 0);
        fault_in_n = 16'hFFF7; idle(4);
        @(negedge clk) status_rd = 1;
        @(negedge clk) status_rd = 0;
        chk("R8 set wins over read", fault_seen, 1);
        fault_in_n = 16'hFFFF; idle(4);
        @(negedge clk) status_rd = 1;
        @(negedge clk) status_rd = 0;
        chk("R8 read after fault gone", fault_seen, 0);
        slot(); idle(2); slot();
        chk("R3 flushed", insert_req, 0);

        // R4: continuous fault on channel 15
        fault_in_n = 16'h7FFF; idle(4);
        for (int f = 0; f < 3; f++) begin
            slot();
            chk("R4 continuous fault each frame", insert_req, 1);
            idle(5);
        end
        fault_in_n = 16'hFFFF; idle(4); slot(); idle(2); slot();
        chk("R4 cleared after release", insert_req, 0);

        // R5: software force
        force_fault = 1; idle(1); slot();
        chk("R5 force inserts", insert_req, 1);
        force_fault = 0; idle(2); slot();
        chk("R5 release stops", insert_req, 0);

        // R6: single-frame strobe
        strobe_cmd(); idle(3); slot();
        chk("R6 strobe inserts", insert_req, 1);
        idle(3); slot();
        chk("R6 strobe only one frame", insert_req, 0);

        // R7: pattern disabled consumes pending fault
        pattern_en = 0;
        strobe_cmd(); idle(3); slot();
        chk("R7 disabled no insert", insert_req, 0);
        pattern_en = 1; idle(2); slot();
        chk("R7 pending discarded", insert_req, 0);

        // R10: fault during an active frame carries to next
        strobe_cmd(); idle(2); slot();
        chk("R10 first frame", insert_req, 1);
        idle(2); strobe_cmd(); idle(3);
        chk("R10 held in frame", insert_req, 1);
        slot();
        chk("R10 carried to next frame", insert_req, 1);
        idle(2); slot();
        chk("R10 then drops", insert_req, 0);

        idle(3);
        finish_run();
    end

endmodule